// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of small unsigned operands and reports it as a residue modulo 3. Each enabled clock adds the operand presented on `opnd_i` to the stored total and folds the result back into the range 0 to 2. The stored total is itself the state of the machine, and `sum_o` shows it directly with no output decoding. The total starts at zero and goes back to zero on reset.

A two-bit field has four codes, but only three residues exist, so one state code and one operand code fall outside the arithmetic. Both have fixed behaviour here, so the block never enters an undefined path. An operand of 3 is taken as its residue, 0, and leaves the total as it is. A stored code of 3, which cannot be reached through the ports, is read as 0, so the next enabled clock loads the operand's residue. The modulus and the length of the reset synchroniser are parameters.

Top module: `mod3_accum`

## Requirements
- R1: On each rising clock edge with `en_i` high and an operand of 0, 1 or 2, the sum becomes (previous sum + operand) mod 3. For example, a sum of 2 with an operand of 2 gives 1.
- R2: An operand of 3 (binary 11) is taken as 0. An enabled clock edge with this operand leaves the sum unchanged.
- R3: If the stored state holds the unused code 3 (binary 11), the next-state logic treats it as 0 and produces (0 + operand) mod 3. This gives 0, 1, 2, 0 for operands 0, 1, 2, 3.
- R4: While `en_i` is low the sum holds its value on every edge, whatever the operand is.
- R5: While `rst_n` is low, `sum_o` is 0 at once, without waiting for a clock edge. After `rst_n` rises, the first two rising edges leave the sum at 0 even with `en_i` high. The third edge is the first one that adds.
- R6: `sum_o` always equals the stored state and never shows the code 3 when it starts from a legal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released through a synchroniser |
| en_i | input | 1 | Enables accumulation on the current edge when high |
| opnd_i | input | 2 | Operand to add; the code 3 counts as 0 |
| sum_o | output | 2 | Stored running sum mod 3: 0, 1 or 2 |

## Verification
Two events can fall in the same cycle. The first pair is a reset assertion and an enabled add. The bench pulls `rst_n` low between edges while `en_i` is high with a non-zero operand, and expects `sum_o` to read 0 before the next edge. It also expects the first two edges after release to ignore the add. The second pair is the unused state code meeting the unused operand code, which only the next-state logic can see. The bench drives a separate instance of that logic with all sixteen state and operand pairs and compares each result with an integer residue computed in the bench. Long random runs with the enable toggling are compared with the same integer model.

// File: rtl/mod3_accum_pkg.sv
package mod3_accum_pkg;
  // Default modulus of the running sum; must be 2 or more.
  localparam int unsigned ACC_MOD_DEFAULT    = 3;
  // Default number of flops in the reset-release synchroniser.
  localparam int unsigned RST_STAGES_DEFAULT = 2;
endpackage

// File: rtl/m3_rst_sync.sv
module m3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  // First stage samples a constant one; later stages shift it along.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= 1'b1;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/m3_next_val.sv
module m3_next_val #(
  parameter int unsigned MOD = 3,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] nxt_o
);
  // One extra bit holds the unfolded sum (at most 2*MOD-2).
  localparam logic [W:0] MOD_V = (W+1)'(MOD);

  logic [W:0] cur_f;
  logic [W:0] opd_f;
  logic [W:0] raw_sum;
  logic [W:0] folded;

  always_comb begin
    // Out-of-range state codes count as zero.
    cur_f   = ({1'b0, cur_i} < MOD_V) ? {1'b0, cur_i} : '0;
    // Operand codes at or above MOD reduce by one subtraction,
    // since 2**W < 2*MOD.
    opd_f   = ({1'b0, opnd_i} >= MOD_V) ? ({1'b0, opnd_i} - MOD_V)
                                         : {1'b0, opnd_i};
    raw_sum = cur_f + opd_f;
    folded  = (raw_sum >= MOD_V) ? (raw_sum - MOD_V) : raw_sum;
    nxt_o   = folded[W-1:0];
  end
endmodule

// File: rtl/m3_state_reg.sv
module m3_state_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/mod3_accum.sv
module mod3_accum
  import mod3_accum_pkg::*;
#(
  parameter  int unsigned MOD        = ACC_MOD_DEFAULT,
  parameter  int unsigned RST_STAGES = RST_STAGES_DEFAULT,
  localparam int unsigned W          = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] sum_o
);
  logic         rst_sync_n;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  m3_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  m3_next_val #(.MOD(MOD), .W(W)) u_next (
    .cur_i  (state_q),
    .opnd_i (opnd_i),
    .nxt_o  (state_d)
  );

  m3_state_reg #(.W(W)) u_state (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (en_i),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  // The state code is the output code.
  assign sum_o = state_q;
endmodule

// File: rtl/mod3_accum_chk.sv
module mod3_accum_chk #(
  parameter  int unsigned MOD = 3,
  localparam int unsigned W   = $clog2(MOD)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_ok,
  input logic         en_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] sum_o
);
  // R1: an enabled legal add gives the integer residue
  p_add_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && en_i && int'(opnd_i) < MOD && int'(sum_o) < MOD)
    |=> int'(sum_o) == (int'($past(sum_o)) + int'($past(opnd_i))) % MOD)
    else $error("p_add_wrap_r1");

  // R2: an out-of-range operand leaves the sum alone
  p_fold_opnd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && en_i && int'(opnd_i) >= MOD) |=> $stable(sum_o))
    else $error("p_fold_opnd_r2");

  // R4: disabled edges hold the sum
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(sum_o))
    else $error("p_hold_r4");

  // R5: while the released reset is still synchronising, the sum stays zero
  p_sync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> sum_o == '0)
    else $error("p_sync_zero_r5");

  // R6: a legal sum never steps into the unused code
  p_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_o) < MOD |=> int'(sum_o) < MOD)
    else $error("p_legal_r6");
endmodule

bind mod3_accum mod3_accum_chk #(.MOD(MOD)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_ok (rst_sync_n),
  .en_i   (en_i),
  .opnd_i (opnd_i),
  .sum_o  (sum_o)
);

// File: tb/sim_mod3_accum.sv
module sim_mod3_accum;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] opnd;
  logic [1:0] sum;
  logic [1:0] u1_cur, u1_opd, u1_nxt;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 1'b0;

  // 125 MHz
  always #4 clk = ~clk;

  mod3_accum u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .opnd_i (opnd),
    .sum_o  (sum)
  );

  // Stand-alone next-state logic, used to reach the unused state code.
  m3_next_val #(.MOD(3), .W(2)) u1 (
    .cur_i  (u1_cur),
    .opnd_i (u1_opd),
    .nxt_o  (u1_nxt)
  );

  // {state, operand, expected next}, worked out by hand
  localparam logic [5:0] VEC [16] = '{
    6'b00_00_00, 6'b00_01_01, 6'b00_10_10, 6'b00_11_00,
    6'b01_00_01, 6'b01_01_10, 6'b01_10_00, 6'b01_11_01,
    6'b10_00_10, 6'b10_01_00, 6'b10_10_01, 6'b10_11_10,
    6'b11_00_00, 6'b11_01_01, 6'b11_10_10, 6'b11_11_00
  };

  function automatic int ref_next(int s, int x);
    int s0 = (s >= 3) ? 0 : s;
    return (s0 + x) % 3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Entered at a falling edge: drive, let one rising edge pass, return at next falling edge.
  task automatic cyc(bit e, logic [1:0] x);
    en   = e;
    opnd = x;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b1;
    opnd  = 2'd1;
    u1_cur = '0;
    u1_opd = '0;
    repeat (3) @(negedge clk);
    chk("R5 sum during reset", int'(sum), 0);

    // Table walk over the next-state logic, including the unused codes.
    for (int i = 0; i < 16; i++) begin
      u1_cur = VEC[i][5:4];
      u1_opd = VEC[i][3:2];
      #1;
      if (VEC[i][5:4] == 2'b11)
        chk("R3 unused state recovery", int'(u1_nxt), int'(VEC[i][1:0]));
      else if (VEC[i][3:2] == 2'b11)
        chk("R2 unused operand code", int'(u1_nxt), int'(VEC[i][1:0]));
      else
        chk("R1 next-state table", int'(u1_nxt), int'(VEC[i][1:0]));
      chk("R1 table vs integer model", int'(u1_nxt),
          ref_next(int'(VEC[i][5:4]), int'(VEC[i][3:2])));
    end
    @(negedge clk);

    // Release with the enable high: two edges ignored, the third adds.
    rst_n = 1'b1;
    cyc(1'b1, 2'd1);
    chk("R5 first edge after release", int'(sum), 0);
    cyc(1'b1, 2'd1);
    chk("R5 second edge after release", int'(sum), 0);
    cyc(1'b1, 2'd1);
    chk("R5 third edge adds", int'(sum), 1);

    cyc(1'b1, 2'd2);
    chk("R1 1+2 wraps", int'(sum), 0);
    cyc(1'b1, 2'd2);
    chk("R1 0+2", int'(sum), 2);
    cyc(1'b1, 2'd2);
    chk("R1 2+2 gives 1", int'(sum), 1);
    cyc(1'b1, 2'd3);
    chk("R2 operand 3 holds", int'(sum), 1);
    cyc(1'b0, 2'd2);
    chk("R4 disabled hold", int'(sum), 1);
    cyc(1'b0, 2'd1);
    chk("R4 disabled hold again", int'(sum), 1);
    model = 1;

    // Random run against the integer model.
    for (int n = 0; n < 3000; n++) begin
      bit         e = ($urandom_range(0, 3) != 0);
      logic [1:0] x = 2'($urandom_range(0, 3));
      cyc(e, x);
      if (e) model = ref_next(model, int'(x));
      if (!e)          chk("R4 random hold", int'(sum), model);
      else if (x == 3) chk("R2 random operand 3", int'(sum), model);
      else             chk("R1 random add", int'(sum), model);
      chk("R6 never unused code", int'(sum == 2'b11), 0);
    end

    // Reset in mid-cycle while an add is enabled.
    en   = 1'b1;
    opnd = 2'd1;
    #2 rst_n = 1'b0;
    #1 chk("R5 async clear before edge", int'(sum), 0);
    @(negedge clk);
    chk("R5 held during reset", int'(sum), 0);
    rst_n = 1'b1;
    cyc(1'b1, 2'd2);
    chk("R5 restart first edge", int'(sum), 0);
    cyc(1'b1, 2'd2);
    chk("R5 restart second edge", int'(sum), 0);
    cyc(1'b1, 2'd2);
    chk("R5 restart third edge adds", int'(sum), 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule